// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the byte stream of an Ethernet receiver. It decides whether each incoming frame is kept, based on the 48-bit destination address at the head of the frame and on a set of acceptance modes. It compares the destination bytes as they arrive against a programmed station address, and it also classifies the address as broadcast, multicast or unicast. One clock after the sixth destination byte it gives an address verdict. One clock after the last byte of the frame it gives a frame verdict. The frame verdict also applies the runt-length rule and the error-flag rule. Both verdicts are held until the next start of frame.

Software writes three registers through a small write port. The filter control register carries the acceptance mode bits and a slice pointer in the same word, so every write to it replaces both. The filter data register loads two station address bytes into the slice chosen by the pointer. The receive configuration register holds the error-acceptance and runt-acceptance bits.

The sequencing is a three-state machine. `ST_IDLE` waits for a start-of-frame byte. `ST_DEST` collects destination bytes 0 to 5. `ST_BODY` counts the rest of the frame. It has these transitions:
- `ST_IDLE`→`ST_DEST` on a start byte that is not also the end byte.
- `ST_DEST`→`ST_BODY` on the sixth destination byte.
- `ST_DEST`→`ST_IDLE` and `ST_BODY`→`ST_IDLE` on an end byte.
- Any state→`ST_DEST` on a new start byte, which abandons the frame in progress.
- Any state→`ST_IDLE` on a byte that is both start and end.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset both verdict outputs are low, the station address is all zeros and every mode bit is clear, so a frame to any destination is rejected.
- R2: A control write with cfg_sel=0 stores cfg_wdata[9:0] as the slice pointer. A data write with cfg_sel=1 and pointer 0, 2 or 4 loads address byte n=pointer from cfg_wdata[7:0] and byte n+1 from cfg_wdata[15:15-7]. Address byte 0 is the first byte on the wire. A data write with any other pointer value changes nothing.
- R3: Broadcast (all six bytes 0xFF) is accepted only when control bits 31 and 30 are both set.
- R4: A multicast destination is one with bit 0 of byte 0 set that is not broadcast. It is accepted when control bit 29 is set. Control bit 21 (hash enable) is stored but accepts nothing. Bit 29 does not accept broadcast.
- R5: Control bit 28 accepts every destination.
- R6: Control bit 27 accepts a destination equal to the station address in all six bytes.
- R7: dst_valid rises exactly one clock after the sixth destination byte. dst_valid and dst_accept then hold until the next start-of-frame byte, which clears both verdicts one clock later.
- R8: frm_valid rises one clock after the end byte. frm_accept is the address verdict AND'ed with two conditions: length ≥ 64 bytes or receive-config bit 4 set, and rx_err low or receive-config bit 5 set.
- R9: A frame that ends before its sixth byte gives dst_valid=1, dst_accept=0 and a rejected frame verdict.
- R10: A register write in the same clock as a destination byte does not affect that byte. The byte is judged against the station address and modes held before the write. The new values apply from the next byte.
- R11: Bytes presented in ST_IDLE without a start flag are ignored and leave both verdicts unchanged. A start byte in the middle of a frame restarts the filter on the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control/pointer, 1 address data, 2 receive config |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | Present byte is the first of a frame |
| rx_eof | input | 1 | Present byte is the last of a frame |
| rx_err | input | 1 | Frame carries a CRC or receive error (sampled with the end byte) |
| rx_data | input | 8 | Frame byte |
| dst_valid | output | 1 | Address verdict is valid |
| dst_accept | output | 1 | Destination address accepted |
| frm_valid | output | 1 | Frame verdict is valid |
| frm_accept | output | 1 | Frame accepted |

## Verification
A register write and a destination comparison can fall in the same clock. The filter may be matching byte 5 while software reloads the slice that holds that byte, or while it rewrites the mode bits. The bench provokes both cases by issuing the write on exactly the cycle that presents the sixth destination byte. It then judges the result in three steps. First, the verdict of that frame must follow the old address or the old mode. Second, a repeat of the same frame must follow the new values. Third, a frame to the newly written address must be accepted.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEST = 2'd1,
        ST_BODY = 2'd2
    } rdf_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_RXCFG = 2'd2;

    localparam int BIT_BC_HI   = 31;
    localparam int BIT_BC_LO   = 30;
    localparam int BIT_ALLMC   = 29;
    localparam int BIT_PROMISC = 28;
    localparam int BIT_MATCH   = 27;
    localparam int BIT_HASH    = 21;
    localparam int BIT_ACC_ERR = 5;
    localparam int BIT_ACC_RUN = 4;

    typedef struct packed {
        logic [1:0] bcast;
        logic       allmc;
        logic       promisc;
        logic       match;
        logic       hash_en;
    } rdf_mode_t;

endpackage

// File: rtl/rdf_regs.sv
module rdf_regs
    import rdf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int PTR_W      = 10,
    localparam int SLICES    = ADDR_BYTES / 2,
    localparam int STA_W     = ADDR_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output logic [STA_W-1:0] station,
    output rdf_mode_t        mode,
    output logic             acc_err,
    output logic             acc_runt
);

    logic [PTR_W-1:0] ptr_q;
    logic             unused_wdata;

    assign unused_wdata = ^{wdata[26:22], wdata[20:16], wdata[3:0] & 4'h0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            mode  <= '0;
        end else if (wr && sel == SEL_CTRL) begin
            ptr_q         <= wdata[PTR_W-1:0];
            mode.bcast    <= wdata[BIT_BC_HI:BIT_BC_LO];
            mode.allmc    <= wdata[BIT_ALLMC];
            mode.promisc  <= wdata[BIT_PROMISC];
            mode.match    <= wdata[BIT_MATCH];
            mode.hash_en  <= wdata[BIT_HASH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_err  <= 1'b0;
            acc_runt <= 1'b0;
        end else if (wr && sel == SEL_RXCFG) begin
            acc_err  <= wdata[BIT_ACC_ERR];
            acc_runt <= wdata[BIT_ACC_RUN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            station <= '0;
        end else if (wr && sel == SEL_DATA) begin
            for (int s = 0; s < SLICES; s++) begin
                if (ptr_q == PTR_W'(2 * s))
                    station[16*s +: 16] <= wdata[15:0];
            end
        end
    end

    assert_ptr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA && (ptr_q[0] || ptr_q >= PTR_W'(ADDR_BYTES)))
        |=> $stable(station));

    assert_slice_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA && ptr_q == '0)
        |=> (station[7:0] == $past(wdata[7:0]) && station[15:8] == $past(wdata[15:8])));

endmodule

// File: rtl/rdf_addr_track.sv
module rdf_addr_track #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 7,
    localparam int STA_W     = ADDR_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             first,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       data,
    input  logic [STA_W-1:0] station,
    output logic             ones_now,
    output logic             match_now,
    output logic             mcast_now
);

    logic       ones_q, match_q, mcast_q;
    logic [7:0] sta_byte;
    logic       in_dest;

    always_comb begin
        sta_byte = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (byte_idx == IDX_W'(k))
                sta_byte = station[8*k +: 8];
        end
    end

    assign in_dest   = first || (byte_idx < IDX_W'(ADDR_BYTES));
    assign ones_now  = (first ? 1'b1 : ones_q)  && (data == 8'hFF);
    assign match_now = (first ? 1'b1 : match_q) && (data == sta_byte);
    assign mcast_now = first ? data[0] : mcast_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q  <= 1'b0;
            match_q <= 1'b0;
            mcast_q <= 1'b0;
        end else if (valid && in_dest) begin
            ones_q  <= ones_now;
            match_q <= match_now;
            mcast_q <= mcast_now;
        end
    end

endmodule

// File: rtl/rdf_fsm.sv
module rdf_fsm
    import rdf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int MIN_FRAME  = 64,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic             ones_now,
    input  logic             match_now,
    input  logic             mcast_now,
    input  rdf_mode_t        mode,
    input  logic             acc_err,
    input  logic             acc_runt,
    output logic [IDX_W-1:0] byte_idx,
    output logic             dst_valid,
    output logic             dst_accept,
    output logic             frm_valid,
    output logic             frm_accept
);

    localparam logic [IDX_W-1:0] LAST_DEST = IDX_W'(ADDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(MIN_FRAME);
    localparam logic [IDX_W-1:0] LEN_MIN1  = IDX_W'(MIN_FRAME - 1);

    rdf_state_e state, state_n;
    logic       addr_hit, last_dest, len_ok, err_ok, addr_final, mid_byte;

    assign mid_byte  = rx_valid && !rx_sof;
    assign last_dest = (byte_idx == LAST_DEST);
    assign addr_hit  = mode.promisc
                     || (ones_now && (&mode.bcast))
                     || (mcast_now && !ones_now && mode.allmc)
                     || (match_now && mode.match);
    assign len_ok    = (byte_idx >= LEN_MIN1) || acc_runt;
    assign err_ok    = !rx_err || acc_err;

    always_comb begin
        addr_final = 1'b0;
        if (state == ST_BODY)
            addr_final = dst_accept;
        else if (state == ST_DEST && last_dest)
            addr_final = addr_hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (rx_valid && rx_sof) begin
            state_n = rx_eof ? ST_IDLE : ST_DEST;
        end else if (rx_valid) begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_DEST: begin
                    if (rx_eof)         state_n = ST_IDLE;
                    else if (last_dest) state_n = ST_BODY;
                end
                ST_BODY: if (rx_eof) state_n = ST_IDLE;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // byte position counter, saturating at the runt limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byte_idx <= '0;
        else if (rx_valid && rx_sof)
            byte_idx <= IDX_W'(1);
        else if (mid_byte && state != ST_IDLE && byte_idx != IDX_MAX)
            byte_idx <= byte_idx + IDX_W'(1);
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_valid  <= 1'b0;
            dst_accept <= 1'b0;
            frm_valid  <= 1'b0;
            frm_accept <= 1'b0;
        end else if (rx_valid && rx_sof) begin
            dst_valid  <= rx_eof;
            dst_accept <= 1'b0;
            frm_valid  <= rx_eof;
            frm_accept <= 1'b0;
        end else if (mid_byte && state != ST_IDLE) begin
            if (state == ST_DEST && (last_dest || rx_eof)) begin
                dst_valid  <= 1'b1;
                dst_accept <= last_dest && addr_hit;
            end
            if (rx_eof) begin
                frm_valid  <= 1'b1;
                frm_accept <= addr_final && len_ok && err_ok;
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !(rx_valid && rx_sof)) |=> (dst_valid && $stable(dst_accept)));

    assert_sof_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof) |=> (!dst_valid && !frm_valid));

    assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mid_byte) |=> ($stable(dst_valid) && $stable(frm_valid)
                                            && $stable(frm_accept)));

    assert_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEST && mid_byte && rx_eof && byte_idx < LAST_DEST)
        |=> (dst_valid && !dst_accept && frm_valid && !frm_accept));

    assert_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mid_byte && rx_eof && byte_idx < LEN_MIN1 && !acc_runt)
        |=> !frm_accept);

    assert_frm_dep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_accept) |-> (dst_valid && dst_accept));

    assert_hash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEST && mid_byte && last_dest && mode.hash_en && mcast_now
         && !ones_now && !mode.allmc && !mode.promisc && !(match_now && mode.match))
        |=> !dst_accept);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rdf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int MIN_FRAME  = 64,
    parameter int PTR_W      = 10,
    localparam int IDX_W     = $clog2(MIN_FRAME + 1),
    localparam int STA_W     = ADDR_BYTES * 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_err,
    input  logic [7:0]  rx_data,
    output logic        dst_valid,
    output logic        dst_accept,
    output logic        frm_valid,
    output logic        frm_accept
);

    logic [STA_W-1:0] station;
    rdf_mode_t        mode;
    logic             acc_err, acc_runt;
    logic             ones_now, match_now, mcast_now;
    logic [IDX_W-1:0] byte_idx, trk_idx;

    assign trk_idx = rx_sof ? '0 : byte_idx;

    rdf_regs #(.ADDR_BYTES(ADDR_BYTES), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .station(station), .mode(mode), .acc_err(acc_err), .acc_runt(acc_runt)
    );

    rdf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .valid(rx_valid), .first(rx_sof),
        .byte_idx(trk_idx), .data(rx_data), .station(station),
        .ones_now(ones_now), .match_now(match_now), .mcast_now(mcast_now)
    );

    rdf_fsm #(.ADDR_BYTES(ADDR_BYTES), .MIN_FRAME(MIN_FRAME), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .ones_now(ones_now),
        .match_now(match_now), .mcast_now(mcast_now), .mode(mode),
        .acc_err(acc_err), .acc_runt(acc_runt), .byte_idx(byte_idx),
        .dst_valid(dst_valid), .dst_accept(dst_accept),
        .frm_valid(frm_valid), .frm_accept(frm_accept)
    );

endmodule

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;

    localparam logic [31:0] M_BC    = 32'hC000_0000;
    localparam logic [31:0] M_BC1   = 32'h8000_0000;
    localparam logic [31:0] M_ALLMC = 32'h2000_0000;
    localparam logic [31:0] M_PROM  = 32'h1000_0000;
    localparam logic [31:0] M_MATCH = 32'h0800_0000;
    localparam logic [31:0] M_HASH  = 32'h0020_0000;
    localparam logic [47:0] STA     = 48'h5544_3322_1102;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST   = 48'h0000_005E_0001;
    localparam logic [47:0] OTHER   = 48'h0F0E_0D0C_0B0A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        dst_valid, dst_accept, frm_valid, frm_accept;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    rx_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data),
        .dst_valid(dst_valid), .dst_accept(dst_accept),
        .frm_valid(frm_valid), .frm_accept(frm_accept)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_all(input string tag, input logic dv, input logic da,
                              input logic fv, input logic fa);
        check({tag, " dst_valid"}, dst_valid, dv);
        check({tag, " dst_accept"}, dst_accept, da);
        check({tag, " frm_valid"}, frm_valid, fv);
        check({tag, " frm_accept"}, frm_accept, fa);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic program_station(input logic [47:0] a, input logic [31:0] m);
        wr(2'd0, m | 32'd0); wr(2'd1, {16'd0, a[15:0]});
        wr(2'd0, m | 32'd2); wr(2'd1, {16'd0, a[31:16]});
        wr(2'd0, m | 32'd4); wr(2'd1, {16'd0, a[47:32]});
    endtask

    task automatic send_frame(input logic [47:0] dst, input int len,
                              input logic err = 1'b0, input logic no_eof = 1'b0,
                              input int cidx = -1, input logic [1:0] csel = 2'd0,
                              input logic [31:0] cdata = 32'd0,
                              input logic chk_t = 1'b0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (chk_t && i == 1) check("R7 cleared after sof", dst_valid, 1'b0);
            if (chk_t && i == 5) check("R7 not yet valid at byte 6", dst_valid, 1'b0);
            if (chk_t && i == 6) check("R7 valid one clock after byte 6", dst_valid, 1'b1);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1) && !no_eof;
            rx_err   = (i == len - 1) ? err : 1'b0;
            rx_data  = (i < 6) ? dst[8*i +: 8] : 8'(i);
            cfg_wr   = (i == cidx);
            cfg_sel  = csel;
            cfg_wdata = cdata;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        expect_all("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(48'h0, 64);
        expect_all("R1 zero station zero mode", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_station();
        program_station(STA, M_MATCH);
        send_frame(STA, 64);
        expect_all("R6 R2 station match", 1'b1, 1'b1, 1'b1, 1'b1);
        send_frame(48'h5544_3322_0211, 64);
        check("R2 swapped byte order rejected", dst_accept, 1'b0);
        send_frame(48'h5644_3322_1102, 64);
        check("R6 last byte differs", dst_accept, 1'b0);
    endtask

    task automatic t_bad_ptr();
        wr(2'd0, M_MATCH | 32'd6); wr(2'd1, 32'h0000_FFFF);
        wr(2'd0, M_MATCH | 32'd1); wr(2'd1, 32'h0000_FFFF);
        send_frame(STA, 64);
        check("R2 bad pointer writes ignored", frm_accept, 1'b1);
    endtask

    task automatic t_bcast();
        wr(2'd0, M_BC);
        send_frame(BCAST, 64);
        check("R3 broadcast accepted", frm_accept, 1'b1);
        send_frame(STA, 64);
        check("R3 unicast rejected in broadcast mode", dst_accept, 1'b0);
        wr(2'd0, M_BC1);
        send_frame(BCAST, 64);
        check("R3 one broadcast bit not enough", dst_accept, 1'b0);
    endtask

    task automatic t_mcast();
        wr(2'd0, M_ALLMC);
        send_frame(MCAST, 64);
        check("R4 multicast accepted", frm_accept, 1'b1);
        send_frame(BCAST, 64);
        check("R4 broadcast not multicast", dst_accept, 1'b0);
        send_frame(OTHER, 64);
        check("R4 unicast rejected", dst_accept, 1'b0);
        wr(2'd0, M_HASH);
        send_frame(MCAST, 64);
        check("R4 hash enable accepts nothing", dst_accept, 1'b0);
    endtask

    task automatic t_promisc();
        wr(2'd0, M_PROM);
        send_frame(OTHER, 64);
        check("R5 any unicast", frm_accept, 1'b1);
        send_frame(MCAST, 64);
        check("R5 any multicast", frm_accept, 1'b1);
    endtask

    task automatic t_timing();
        wr(2'd0, M_MATCH);
        send_frame(STA, 64, .chk_t(1'b1));
        repeat (5) @(negedge clk);
        expect_all("R7 verdict held while idle", 1'b1, 1'b1, 1'b1, 1'b1);
        send_frame(OTHER, 64, .chk_t(1'b1));
        check("R7 new frame verdict", dst_accept, 1'b0);
    endtask

    task automatic t_length_err();
        wr(2'd0, M_MATCH); wr(2'd2, 32'h0);
        send_frame(STA, 60);
        expect_all("R8 runt", 1'b1, 1'b1, 1'b1, 1'b0);
        send_frame(STA, 63);
        check("R8 63 bytes is runt", frm_accept, 1'b0);
        send_frame(STA, 64);
        check("R8 64 bytes accepted", frm_accept, 1'b1);
        wr(2'd2, 32'h10);
        send_frame(STA, 60);
        check("R8 runt accepted with bit 4", frm_accept, 1'b1);
        wr(2'd2, 32'h0);
        send_frame(STA, 64, .err(1'b1));
        check("R8 error rejected", frm_accept, 1'b0);
        wr(2'd2, 32'h20);
        send_frame(STA, 64, .err(1'b1));
        check("R8 error accepted with bit 5", frm_accept, 1'b1);
        send_frame(STA, 60, .err(1'b1));
        check("R8 runt error with only bit 5", frm_accept, 1'b0);
        wr(2'd2, 32'h30);
        send_frame(STA, 60, .err(1'b1));
        check("R8 runt error both enabled", frm_accept, 1'b1);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_short();
        wr(2'd0, M_PROM);
        send_frame(OTHER, 4);
        expect_all("R9 four byte frame", 1'b1, 1'b0, 1'b1, 1'b0);
        send_frame(OTHER, 1);
        expect_all("R9 one byte frame", 1'b1, 1'b0, 1'b1, 1'b0);
        wr(2'd2, 32'h10);
        send_frame(OTHER, 6);
        expect_all("R9 six byte frame complete", 1'b1, 1'b1, 1'b1, 1'b1);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_restart_idle();
        wr(2'd0, M_MATCH);
        send_frame(OTHER, 3, .no_eof(1'b1));
        send_frame(STA, 64);
        expect_all("R11 restart on mid-frame sof", 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_data = 8'hFF;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        expect_all("R11 stray idle bytes ignored", 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_collide();
        program_station(STA, M_MATCH);
        send_frame(STA, 64, .cidx(5), .csel(2'd1), .cdata(32'h0000_AA99));
        check("R10 byte judged against old slice", frm_accept, 1'b1);
        send_frame(STA, 64);
        check("R10 old address gone", dst_accept, 1'b0);
        send_frame(48'hAA99_3322_1102, 64);
        check("R10 new address accepted", frm_accept, 1'b1);
        send_frame(OTHER, 64, .cidx(5), .csel(2'd0), .cdata(M_PROM));
        check("R10 mode write applies after byte", dst_accept, 1'b0);
        send_frame(OTHER, 64);
        check("R10 new mode applies", dst_accept, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_station();
        t_bad_ptr();
        t_bcast();
        t_mcast();
        t_promisc();
        t_timing();
        t_length_err();
        t_short();
        t_restart_idle();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule